// File: doc/BRIEF.md
# Stack-Machine Subtract and Compare Unit

This block is the arithmetic and comparison datapath of a small 32-bit stack processor. Each cycle it takes the top-of-stack word and the word beneath it, and it always registers one 33-bit difference: the word beneath the top minus the top word, with both operands zero-extended by one bit. The results for five instructions all come from that single registered difference. The instructions are subtract, equal, not-equal, signed less-than and signed less-than-or-equal.

The control logic issues an operation by raising `issue_i` with a 6-bit opcode. One cycle later the block presents the word to write back to the new top of stack, and raises `done_o` for that one cycle. A zero detect on the registered difference provides the equality flag. Paired instructions are told apart by single opcode bits that are XORed into that flag. Signed ordering uses the borrow bit of the difference, corrected by the XOR of the two operands' sign bits. Instruction fetch, stack-pointer update and memory access are outside this block.

Top module: `stk_subcmp_unit`

## Requirements
- R1: While `rst_ni` is low, `done_o` is 0 and `wb_data_o` is all zeros.
- R2: An issue with a supported opcode (36, 37, 46, 48 or 49) raises `done_o` for exactly the following cycle.
- R3: Opcode 49 (subtract) returns `(nos_i - tos_i)` modulo 2^32 on `wb_data_o`.
- R4: Opcode 46 (equal) returns 1 in bit 0 when `nos_i == tos_i`, and 0 otherwise.
- R5: Opcode 48 (not-equal) returns 1 in bit 0 when `nos_i != tos_i`, and 0 otherwise.
- R6: Opcode 36 (signed less-than) returns 1 in bit 0 when `tos_i < nos_i` as two's-complement values, including when the operand signs differ.
- R7: Opcode 37 (signed less-or-equal) returns 1 in bit 0 when `tos_i <= nos_i` as two's-complement values.
- R8: For opcodes 36, 37, 46 and 48, bits 31 to 1 of `wb_data_o` are zero.
- R9: `wb_data_o` is all zeros in every cycle where `done_o` is low.
- R10: Issues in consecutive cycles each produce their own result in the following cycle, unaffected by the operands of their neighbours.
- R11: An issue with any other opcode (including 38 and 47) raises no `done_o` and yields a zero `wb_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Operation strobe for the current opcode and operands |
| opcode_i | input | 6 | Instruction code |
| tos_i | input | 32 | Top-of-stack word |
| nos_i | input | 32 | Word below the top of stack |
| wb_data_o | output | 32 | Word to write back to the new top of stack |
| done_o | output | 1 | One-cycle pulse that marks a valid write-back |

## Verification
Two things can happen at the block's edge in the same cycle. The result of the previous issue is being presented, and the difference register is already taking the operands of the next issue. The bench provokes this with unbroken runs of issues, in which every corner operand pair goes through all five opcodes back-to-back, with unsupported opcodes mixed in. A behavioural reference model predicts `done_o` and `wb_data_o` for each cycle from the inputs of the cycle before. The two are compared on every clock, so a result that took the next cycle's operands, or a pulse that was stretched or dropped, is caught in the cycle it appears.

// File: rtl/stk_subcmp_pkg.sv
package stk_subcmp_pkg;

  localparam int unsigned OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_SLT = 6'd36;
  localparam logic [OPC_W-1:0] OPC_SLE = 6'd37;
  localparam logic [OPC_W-1:0] OPC_EQ  = 6'd46;
  localparam logic [OPC_W-1:0] OPC_NE  = 6'd48;
  localparam logic [OPC_W-1:0] OPC_SUB = 6'd49;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_SUB   = 2'd1,
    KIND_EQNEQ = 2'd2,
    KIND_SCMP  = 2'd3
  } op_kind_e;

  // Maps an opcode onto the result path that serves it.
  function automatic op_kind_e decode_kind(input logic [OPC_W-1:0] opc);
    op_kind_e k;
    case (opc)
      OPC_SUB:          k = KIND_SUB;
      OPC_EQ, OPC_NE:   k = KIND_EQNEQ;
      OPC_SLT, OPC_SLE: k = KIND_SCMP;
      default:          k = KIND_NONE;
    endcase
    return k;
  endfunction

  // Bit 4 separates equal from not-equal (46 vs 48).
  localparam int unsigned SENSE_BIT  = 4;
  // Bit 0 separates strict from non-strict ordering (36 vs 37).
  localparam int unsigned STRICT_BIT = 0;

endpackage

// File: rtl/stk_diff_stage.sv
// Registered difference: next-on-stack minus top-of-stack, one bit wider
// than the word, recomputed on every rising edge.
module stk_diff_stage #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] tos_i,
  input  logic [WORD_W-1:0] nos_i,
  output logic [WORD_W:0]   diff_q_o,
  output logic              sign_mix_q_o
);

  localparam int unsigned EXT_W = WORD_W + 1;

  logic [EXT_W-1:0] diff_d;
  logic             sign_mix_d;

  always_comb begin
    diff_d     = {1'b0, nos_i} - {1'b0, tos_i};
    sign_mix_d = nos_i[WORD_W-1] ^ tos_i[WORD_W-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      diff_q_o     <= '0;
      sign_mix_q_o <= 1'b0;
    end else begin
      diff_q_o     <= diff_d;
      sign_mix_q_o <= sign_mix_d;
    end
  end

endmodule

// File: rtl/stk_zero_detect.sv
// Zero detect built as a chunked OR tree; CHUNK_W sets the first-level fan-in.
module stk_zero_detect #(
  parameter int unsigned VEC_W   = 33,
  parameter int unsigned CHUNK_W = 8
) (
  input  logic [VEC_W-1:0] vec_i,
  output logic             zero_o
);

  localparam int unsigned N_CHUNK = (VEC_W + CHUNK_W - 1) / CHUNK_W;
  localparam int unsigned PAD_W   = N_CHUNK * CHUNK_W;

  logic [PAD_W-1:0]   padded;
  logic [N_CHUNK-1:0] chunk_any;

  assign padded = PAD_W'(vec_i);

  for (genvar g = 0; g < N_CHUNK; g++) begin : g_chunk
    assign chunk_any[g] = |padded[g*CHUNK_W +: CHUNK_W];
  end

  assign zero_o = ~|chunk_any;

endmodule

// File: rtl/stk_result_sel.sv
// Forms the write-back word from the registered difference and flags.
module stk_result_sel
  import stk_subcmp_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic            active_i,
  input  op_kind_e        kind_i,
  input  logic            strict_n_i,
  input  logic            sense_i,
  input  logic [WORD_W:0] diff_i,
  input  logic            sign_mix_i,
  input  logic            eq_flag_i,
  output logic            borrow_fix_o,
  output logic [WORD_W-1:0] wb_data_o
);

  // Equality, inverted by the opcode's sense bit for not-equal.
  function automatic logic f_eqneq(input logic eq, input logic sense);
    return eq ^ sense;
  endfunction

  // Borrow of the zero-extended difference, corrected when signs differ.
  function automatic logic f_signed_borrow(input logic borrow, input logic mix);
    return borrow ^ mix;
  endfunction

  // Ordering bit: strict form removes the equal case, then the sense flips
  // so that 1 means top-of-stack is below (or at) next-on-stack.
  function automatic logic f_order(input logic fixed, input logic eq,
                                   input logic strict_n);
    return ~(fixed ^ (~strict_n & eq));
  endfunction

  assign borrow_fix_o = f_signed_borrow(diff_i[WORD_W], sign_mix_i);

  always_comb begin
    wb_data_o = '0;
    if (active_i) begin
      unique case (kind_i)
        KIND_SUB:   wb_data_o    = diff_i[WORD_W-1:0];
        KIND_EQNEQ: wb_data_o[0] = f_eqneq(eq_flag_i, sense_i);
        KIND_SCMP:  wb_data_o[0] = f_order(borrow_fix_o, eq_flag_i, strict_n_i);
        default:    wb_data_o    = '0;
      endcase
    end
  end

endmodule

// File: rtl/stk_subcmp_unit.sv
module stk_subcmp_unit
  import stk_subcmp_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ZCHUNK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [5:0]        opcode_i,
  input  logic [DATA_W-1:0] tos_i,
  input  logic [DATA_W-1:0] nos_i,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              done_o
);

  localparam int unsigned DIFF_W = DATA_W + 1;

  // Named internal events, visible to the bound checker.
  logic [DIFF_W-1:0] diff_q;
  logic              sign_mix_q;
  logic              eq_flag;
  logic              borrow_fix;
  op_kind_e          kind_d;
  op_kind_e          kind_q;
  logic              strict_n_q;
  logic              sense_q;
  logic              pending_q;

  assign kind_d = decode_kind(opcode_i);

  stk_diff_stage #(
    .WORD_W(DATA_W)
  ) u_diff (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tos_i       (tos_i),
    .nos_i       (nos_i),
    .diff_q_o    (diff_q),
    .sign_mix_q_o(sign_mix_q)
  );

  stk_zero_detect #(
    .VEC_W  (DIFF_W),
    .CHUNK_W(ZCHUNK_W)
  ) u_zero (
    .vec_i (diff_q),
    .zero_o(eq_flag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q  <= 1'b0;
      kind_q     <= KIND_NONE;
      strict_n_q <= 1'b0;
      sense_q    <= 1'b0;
    end else begin
      pending_q  <= issue_i && (kind_d != KIND_NONE);
      kind_q     <= kind_d;
      strict_n_q <= opcode_i[STRICT_BIT];
      sense_q    <= opcode_i[SENSE_BIT];
    end
  end

  stk_result_sel #(
    .WORD_W(DATA_W)
  ) u_sel (
    .active_i    (pending_q),
    .kind_i      (kind_q),
    .strict_n_i  (strict_n_q),
    .sense_i     (sense_q),
    .diff_i      (diff_q),
    .sign_mix_i  (sign_mix_q),
    .eq_flag_i   (eq_flag),
    .borrow_fix_o(borrow_fix),
    .wb_data_o   (wb_data_o)
  );

  assign done_o = pending_q;

endmodule

// File: rtl/stk_subcmp_chk.sv
module stk_subcmp_chk
  import stk_subcmp_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         issue_i,
  input logic [5:0]   opcode_i,
  input logic [W-1:0] tos_i,
  input logic [W-1:0] nos_i,
  input logic [W-1:0] wb_data_o,
  input logic         done_o,
  input logic         eq_flag,
  input logic         borrow_fix
);

  logic supported;
  logic flag_op;
  assign supported = (opcode_i == OPC_SUB) || (opcode_i == OPC_EQ) ||
                     (opcode_i == OPC_NE)  || (opcode_i == OPC_SLT) ||
                     (opcode_i == OPC_SLE);
  assign flag_op   = supported && (opcode_i != OPC_SUB);

  p_done_after_issue_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && supported) |=> done_o);

  p_no_done_unsupported_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(issue_i && supported) |=> !done_o);

  p_sub_value_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && opcode_i == OPC_SUB) |=> (wb_data_o == $past(nos_i - tos_i)));

  p_eq_flag_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nos_i == tos_i) |=> eq_flag);

  p_eq_flag_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nos_i != tos_i) |=> !eq_flag);

  p_signed_borrow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (borrow_fix == ($past($signed(nos_i)) < $past($signed(tos_i)))));

  p_flag_narrow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && flag_op) |=> (wb_data_o[W-1:1] == '0));

  p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (wb_data_o == '0));

  always_comb begin
    if (!rst_ni) begin
      a_reset_quiet_r1: assert (!done_o || $isunknown(done_o));
    end
  end

endmodule

bind stk_subcmp_unit stk_subcmp_chk #(.W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .issue_i   (issue_i),
  .opcode_i  (opcode_i),
  .tos_i     (tos_i),
  .nos_i     (nos_i),
  .wb_data_o (wb_data_o),
  .done_o    (done_o),
  .eq_flag   (eq_flag),
  .borrow_fix(borrow_fix)
);

// File: tb/stk_subcmp_unit_tb_top.sv
module stk_subcmp_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        issue_i;
  logic [5:0]  opcode_i;
  logic [31:0] tos_i;
  logic [31:0] nos_i;
  logic [31:0] wb_data_o;
  logic        done_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  stk_subcmp_unit dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .issue_i  (issue_i),
    .opcode_i (opcode_i),
    .tos_i    (tos_i),
    .nos_i    (nos_i),
    .wb_data_o(wb_data_o),
    .done_o   (done_o)
  );

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  logic        exp_done;
  logic [31:0] exp_data;
  string exp_tag;
  string section;

  // Behavioural reference: what the block should present one cycle later.
  function automatic void model(input bit v, input logic [5:0] op,
                                input logic [31:0] t, input logic [31:0] n,
                                output logic d, output logic [31:0] r,
                                output string tag);
    longint st = longint'($signed(t));
    longint sn = longint'($signed(n));
    d = 1'b0; r = 32'h0; tag = "R9";
    if (v) begin
      d = 1'b1;
      case (op)
        6'd49: begin r = n - t;                     tag = "R3"; end
        6'd46: begin r = (n == t) ? 32'd1 : 32'd0;  tag = "R4 R8"; end
        6'd48: begin r = (n != t) ? 32'd1 : 32'd0;  tag = "R5 R8"; end
        6'd36: begin r = (st < sn) ? 32'd1 : 32'd0; tag = "R6 R8"; end
        6'd37: begin r = (st <= sn) ? 32'd1 : 32'd0; tag = "R7 R8"; end
        default: begin d = 1'b0; r = 32'h0;         tag = "R11"; end
      endcase
    end
  endfunction

  task automatic check_now();
    checks++;
    if (done_o !== exp_done || wb_data_o !== exp_data) begin
      errors++;
      $display("FAIL %s R2 [%s]: done=%0b data=%08h expected done=%0b data=%08h",
               exp_tag, section, done_o, wb_data_o, exp_done, exp_data);
    end
  endtask

  // Checks the prediction made last cycle, then drives the next inputs.
  task automatic cycle(input bit v, input logic [5:0] op,
                       input logic [31:0] t, input logic [31:0] n);
    @(negedge clk);
    check_now();
    issue_i  = v;
    opcode_i = op;
    tos_i    = t;
    nos_i    = n;
    model(v, op, t, n, exp_done, exp_data, exp_tag);
  endtask

  function automatic logic [5:0] pick_op(input int sel);
    case (sel)
      0: return 6'd49;
      1: return 6'd46;
      2: return 6'd48;
      3: return 6'd36;
      4: return 6'd37;
      5: return 6'd47;
      6: return 6'd38;
      default: return 6'($urandom_range(0, 63));
    endcase
  endfunction

  logic [31:0] corner_t [10];
  logic [31:0] corner_n [10];

  initial begin
    corner_t[0] = 32'h0000_0000; corner_n[0] = 32'h0000_0000;
    corner_t[1] = 32'h8000_0000; corner_n[1] = 32'h7FFF_FFFF;
    corner_t[2] = 32'h7FFF_FFFF; corner_n[2] = 32'h8000_0000;
    corner_t[3] = 32'h0000_0005; corner_n[3] = 32'h8000_0005;
    corner_t[4] = 32'h8000_0005; corner_n[4] = 32'h0000_0005;
    corner_t[5] = 32'hFFFF_FFFF; corner_n[5] = 32'h0000_0000;
    corner_t[6] = 32'h0000_0000; corner_n[6] = 32'hFFFF_FFFF;
    corner_t[7] = 32'h8000_0000; corner_n[7] = 32'h8000_0000;
    corner_t[8] = 32'h1234_5678; corner_n[8] = 32'h1234_5678;
    corner_t[9] = 32'h0000_0000; corner_n[9] = 32'h8000_0000;

    rst_ni = 1'b0; issue_i = 1'b0; opcode_i = 6'd0; tos_i = '0; nos_i = '0;
    exp_done = 1'b0; exp_data = 32'h0; exp_tag = "R1"; section = "reset";
    // R1: outputs quiet while reset is held, even with an issue pending.
    repeat (2) begin @(negedge clk); check_now(); end
    issue_i = 1'b1; opcode_i = 6'd49; tos_i = 32'd1; nos_i = 32'd9;
    repeat (2) begin @(negedge clk); check_now(); end
    issue_i = 1'b0;
    rst_ni = 1'b1;
    exp_tag = "R9";

    // R10: every corner pair through all opcodes, unbroken issue stream.
    section = "R10 back-to-back corners";
    for (int c = 0; c < 10; c++) begin
      for (int s = 0; s < 7; s++) begin
        cycle(1'b1, pick_op(s), corner_t[c], corner_n[c]);
      end
    end

    // R2/R9: isolated issues separated by idle cycles.
    section = "R2 isolated";
    for (int c = 0; c < 10; c++) begin
      cycle(1'b1, pick_op(c % 5), corner_t[c], corner_n[c]);
      cycle(1'b0, 6'd49, corner_n[c], corner_t[c]);
    end

    // Random traffic with equal and sign-only-different operands mixed in.
    section = "random";
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] t;
      logic [31:0] n;
      int k;
      t = $urandom();
      n = $urandom();
      k = $urandom_range(0, 7);
      if (k == 0) n = t;
      else if (k == 1) n = t ^ 32'h8000_0000;
      else if (k == 2) n = t + 32'd1;
      cycle(($urandom_range(0, 3) != 0), pick_op($urandom_range(0, 7)), t, n);
    end

    section = "drain";
    cycle(1'b0, 6'd0, 32'h0, 32'h0);
    cycle(1'b0, 6'd0, 32'h0, 32'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule